// File: doc/BRIEF.md
# Interrupt Vector Table and Pending-Bit Window

This block holds the message-signalled interrupt vector table of a device function, together with the bits that record which vectors have an interrupt waiting. Software reaches it through a 4 KiB register page on a simple 32-bit request bus. Each implemented vector has four 32-bit words in the lower half of the page. The pending bits sit in the upper half. Only full 32-bit accesses take effect. Narrower reads return zero and narrower writes are dropped.

A message dispatcher sits beside the block. It sees every vector's 64-bit target address, its 32-bit payload and its mask bit. It sets or clears pending bits as it defers or delivers messages. When software clears a vector's mask bit, the block sends a one-cycle recheck pulse on that vector's lane. The dispatcher can then deliver any message that was held while the vector was masked.

Top module: `msix_vec_window`

## Requirements
- R1: Vector v occupies byte offsets 16v to 16v+15. Word 0 holds the low address, word 1 the high address, word 2 the payload and word 3 the control word. All four words read back what was written. `vec_addr` lane v carries {high, low} and `vec_data` lane v carries the payload.
- R2: Bit 0 of a vector's control word is its mask bit and drives `vec_masked[v]`. The mask changes only through a bus write.
- R3: Only address bits [11:2] select a register. Bits [1:0] and every bit above bit 11 are ignored, so the page repeats every 4 KiB.
- R4: Every read request produces `rsp_valid` for exactly one cycle, in the cycle after the request, with the data on `rsp_rdata`. No response appears without a read.
- R5: The pending word is at byte offset 0x800. Bit v of that word, which is bit v mod 8 of byte v div 8, belongs to vector v. Software can read and write it with a full-word access.
- R6: Access size is encoded in `req_size` as 0 = byte, 1 = halfword, 2 = word and 3 = reserved. Any access other than a word access reads as zero, still with a response, and a write of that kind changes no state.
- R7: After reset, every word reads zero except each implemented control word, which reads 1 (masked). No bit is pending.
- R8: A word write to a control word that takes the mask bit from 1 to 0 raises `recheck[v]` for exactly the next cycle. A write that leaves the mask at 0, leaves it at 1, or sets it from 0 to 1 raises no pulse.
- R9: `pend_set[v]` sets pending bit v and `pend_clr[v]` clears it, visible one cycle later. If both are asserted in the same cycle, set wins.
- R10: If software writes the pending word in a cycle when a dispatcher request touches a byte of it, software's value for that whole byte is dropped. The other bytes take software's value.
- R11: Vector slots at index NUM_VEC or above, pending bits at index NUM_VEC or above, and any other upper-half word all read as zero. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Byte address, taken modulo 4 KiB |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| vec_addr | output | NUM_VEC*64 | Per-vector 64-bit message address |
| vec_data | output | NUM_VEC*32 | Per-vector message payload |
| vec_masked | output | NUM_VEC | Per-vector mask bit |
| pend_set | input | NUM_VEC | Dispatcher request to set a pending bit |
| pend_clr | input | NUM_VEC | Dispatcher request to clear a pending bit |
| pending | output | NUM_VEC | Current pending bits |
| recheck | output | NUM_VEC | One-cycle pulse when a vector is unmasked by a write |

## Verification
The hardest case to reach is a collision: a software write to the pending word in the same cycle as a dispatcher request that falls in one of its bytes. Reaching it needs the bus request and the dispatcher strobe lined up on the same edge. The bench raises `pend_clr` for one bit in the cycle where it issues the word write. It then checks that the colliding byte kept its old contents minus the cleared bit, while the other bytes took the new value. The bench is built with fewer vectors than the maximum, so the same write also shows that bits past the last vector stay zero. The recheck pulse is checked by driving all four mask transitions on one vector.

// File: rtl/msix_win_pkg.sv
package msix_win_pkg;

    localparam int MAX_VEC     = 32;
    localparam int PAGE_BITS   = 12;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        EW_ADDR_LO = 2'd0,
        EW_ADDR_HI = 2'd1,
        EW_DATA    = 2'd2,
        EW_CTRL    = 2'd3
    } entry_word_e;

endpackage

// File: rtl/msix_win_decode.sv
module msix_win_decode #(
    parameter int NUM_VEC = 32,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ent_hit,
    output logic              pend_hit,
    output logic [IDX_W-1:0]  vec_idx,
    output msix_win_pkg::entry_word_e word_sel
);
    // Bits below the word and above the page carry no selection.
    logic unused_addr_bits;
    assign unused_addr_bits = ^{req_addr[ADDR_W-1:msix_win_pkg::PAGE_BITS], req_addr[1:0]};

    logic       upper_half;
    logic [6:0] slot_num;

    always_comb begin
        upper_half = req_addr[11];
        slot_num   = req_addr[10:4];
        ent_hit    = !upper_half && (32'(slot_num) < NUM_VEC);
        // NUM_VEC never exceeds 32, so a single pending word exists.
        pend_hit   = upper_half && (req_addr[10:2] == 9'd0);
        vec_idx    = req_addr[4 +: IDX_W];
        word_sel   = msix_win_pkg::entry_word_e'(req_addr[3:2]);
    end

endmodule

// File: rtl/msix_win_pend.sv
module msix_win_pend #(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] pend_set,
    input  logic [NUM_VEC-1:0] pend_clr,
    input  logic               sw_we,
    input  logic [31:0]        sw_wdata,
    output logic [NUM_VEC-1:0] pend_q
);
    localparam int LANES = (NUM_VEC + 7) / 8;

    typedef struct packed {
        logic [NUM_VEC-1:0] bits;
    } pend_st_t;

    pend_st_t         st_d, st_q;
    logic [LANES-1:0] lane_busy;
    logic [LANES-1:0] lane_we;

    always_comb begin
        lane_busy = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (pend_set[i] || pend_clr[i]) lane_busy[i / 8] = 1'b1;
        end
        for (int b = 0; b < LANES; b++) begin
            lane_we[b] = sw_we && !lane_busy[b];
        end
        st_d = st_q;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (lane_we[i / 8]) st_d.bits[i] = sw_wdata[i];
            if (pend_clr[i])    st_d.bits[i] = 1'b0;
            if (pend_set[i])    st_d.bits[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.bits;

    generate
        for (genvar g = 0; g < NUM_VEC; g++) begin : g_chk
            a_r9_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
                pend_set[g] |=> pend_q[g]);
            a_r9_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_clr[g] && !pend_set[g]) |=> !pend_q[g]);
            a_r10_busy_lane_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (!pend_set[g] && !pend_clr[g] && lane_busy[g / 8]) |=> $stable(pend_q[g]));
        end
    endgenerate

endmodule

// File: rtl/msix_vec_window.sv
module msix_vec_window #(
    parameter int NUM_VEC = 32,
    parameter int ADDR_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    output logic [31:0]           rsp_rdata,
    output logic [NUM_VEC*64-1:0] vec_addr,
    output logic [NUM_VEC*32-1:0] vec_data,
    output logic [NUM_VEC-1:0]    vec_masked,
    input  logic [NUM_VEC-1:0]    pend_set,
    input  logic [NUM_VEC-1:0]    pend_clr,
    output logic [NUM_VEC-1:0]    pending,
    output logic [NUM_VEC-1:0]    recheck
);
    import msix_win_pkg::*;

    localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    typedef struct packed {
        logic [NUM_VEC-1:0][31:0] lo;
        logic [NUM_VEC-1:0][31:0] hi;
        logic [NUM_VEC-1:0][31:0] dat;
        logic [NUM_VEC-1:0][31:0] ctl;
        logic                     rsp_v;
        logic [31:0]              rdata;
        logic [NUM_VEC-1:0]       rchk;
    } win_st_t;

    win_st_t     st_d, st_q;
    logic        ent_hit, pend_hit;
    logic [IDX_W-1:0] vec_idx;
    entry_word_e word_sel;
    logic        word_ok, do_wr, do_rd, pend_we;
    logic [NUM_VEC-1:0] pend_bits;

    msix_win_decode #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_decode (
        .req_addr (req_addr),
        .ent_hit  (ent_hit),
        .pend_hit (pend_hit),
        .vec_idx  (vec_idx),
        .word_sel (word_sel)
    );

    msix_win_pend #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_set (pend_set),
        .pend_clr (pend_clr),
        .sw_we    (pend_we),
        .sw_wdata (req_wdata),
        .pend_q   (pend_bits)
    );

    always_comb begin
        word_ok = req_valid && (acc_size_e'(req_size) == SZ_WORD);
        do_wr   = word_ok && req_write;
        do_rd   = req_valid && !req_write;
        pend_we = do_wr && pend_hit;

        st_d       = st_q;
        st_d.rsp_v = do_rd;
        st_d.rdata = '0;
        st_d.rchk  = '0;

        if (do_rd && word_ok) begin
            if (ent_hit) begin
                case (word_sel)
                    EW_ADDR_LO: st_d.rdata = st_q.lo[vec_idx];
                    EW_ADDR_HI: st_d.rdata = st_q.hi[vec_idx];
                    EW_DATA:    st_d.rdata = st_q.dat[vec_idx];
                    default:    st_d.rdata = st_q.ctl[vec_idx];
                endcase
            end else if (pend_hit) begin
                st_d.rdata = 32'(pend_bits);
            end
        end

        if (do_wr && ent_hit) begin
            case (word_sel)
                EW_ADDR_LO: st_d.lo[vec_idx]  = req_wdata;
                EW_ADDR_HI: st_d.hi[vec_idx]  = req_wdata;
                EW_DATA:    st_d.dat[vec_idx] = req_wdata;
                default: begin
                    if (st_q.ctl[vec_idx][0] && !req_wdata[0]) st_d.rchk[vec_idx] = 1'b1;
                    st_d.ctl[vec_idx] = req_wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NUM_VEC; i++) st_q.ctl[i] <= 32'd1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_rdata = st_q.rdata;
    assign recheck   = st_q.rchk;
    assign pending   = pend_bits;

    generate
        for (genvar g = 0; g < NUM_VEC; g++) begin : g_lane
            assign vec_addr[g*64 +: 64] = {st_q.hi[g], st_q.lo[g]};
            assign vec_data[g*32 +: 32] = st_q.dat[g];
            assign vec_masked[g]        = st_q.ctl[g][0];

            a_r8_pulse_needs_unmask: assert property (@(posedge clk) disable iff (!rst_n)
                recheck[g] |-> $fell(vec_masked[g]));
        end
    endgenerate

    a_r4_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    a_r4_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
    a_r6_narrow_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size != 2'd2) |=> (rsp_rdata == 32'd0));
    a_r6_narrow_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size != 2'd2)
        |=> ($stable(vec_addr) && $stable(vec_data) && $stable(vec_masked)));
    a_r2_mask_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(vec_masked));
    a_r8_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(recheck));

endmodule

// File: tb/msix_vec_window_bench.sv
`timescale 1ns/1ps
module msix_vec_window_bench;
    localparam int NV = 20;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_size = 2'd2;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NV*64-1:0] vec_addr;
    logic [NV*32-1:0] vec_data;
    logic [NV-1:0] vec_masked, pending, recheck;
    logic [NV-1:0] pend_set = '0, pend_clr = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    msix_vec_window #(.NUM_VEC(NV), .ADDR_W(AW)) u_msix_vec_window (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .vec_addr(vec_addr),
        .vec_data(vec_data), .vec_masked(vec_masked), .pend_set(pend_set),
        .pend_clr(pend_clr), .pending(pending), .recheck(recheck)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 18;
    localparam step_t TBL [NSTEP] = '{
        '{1'b0, 2'd2, 16'h000C, 32'h0,         32'h1,         8'd7},  // R7 ctrl reset masked
        '{1'b0, 2'd2, 16'h0000, 32'h0,         32'h0,         8'd7},  // R7 word zero
        '{1'b1, 2'd2, 16'h0010, 32'hAAAA0001,  32'h0,         8'd1},  // R1 vec1 addr lo
        '{1'b1, 2'd2, 16'h0014, 32'h11112222,  32'h0,         8'd1},  // R1 vec1 addr hi
        '{1'b1, 2'd2, 16'h0018, 32'h0000BEEF,  32'h0,         8'd1},  // R1 vec1 payload
        '{1'b0, 2'd2, 16'h0010, 32'h0,         32'hAAAA0001,  8'd1},  // R1 read back
        '{1'b0, 2'd2, 16'h1018, 32'h0,         32'h0000BEEF,  8'd3},  // R3 alias page
        '{1'b0, 2'd2, 16'h0016, 32'h0,         32'h11112222,  8'd3},  // R3 low bits ignored
        '{1'b1, 2'd0, 16'h0010, 32'h0,         32'h0,         8'd6},  // R6 byte write dropped
        '{1'b0, 2'd2, 16'h0010, 32'h0,         32'hAAAA0001,  8'd6},  // R6 value kept
        '{1'b0, 2'd1, 16'h0010, 32'h0,         32'h0,         8'd6},  // R6 half read zero
        '{1'b1, 2'd2, 16'h0140, 32'hFFFFFFFF,  32'h0,         8'd11}, // R11 slot 20 write
        '{1'b0, 2'd2, 16'h0140, 32'h0,         32'h0,         8'd11}, // R11 slot 20 reads 0
        '{1'b1, 2'd2, 16'h0800, 32'hFFFFFFFF,  32'h0,         8'd5},  // R5 pend write
        '{1'b0, 2'd2, 16'h0800, 32'h0,         32'h000FFFFF,  8'd5},  // R5 only NV bits
        '{1'b0, 2'd2, 16'h0804, 32'h0,         32'h0,         8'd11}, // R11 other upper word
        '{1'b1, 2'd2, 16'h0800, 32'h0,         32'h0,         8'd5},  // R5 clear all
        '{1'b0, 2'd2, 16'h0800, 32'h0,         32'h0,         8'd5}   // R5 read cleared
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one bus access on a falling edge; response is sampled one cycle later.
    task automatic bus(input logic wr, input logic [1:0] sz, input logic [15:0] addr,
                       input logic [31:0] wd, output logic v, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        v = rsp_valid; rd = rsp_rdata;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic v;
        logic [31:0] rd;
        logic [NV-1:0] rc_after;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state at the ports
        chk(vec_masked == {NV{1'b1}}, "R7 mask", 64'(vec_masked), 64'({NV{1'b1}}));
        chk(pending == '0, "R7 pending", 64'(pending), 0);
        chk(!rsp_valid && recheck == '0, "R7 idle", 64'({rsp_valid, recheck}), 0);

        for (int s = 0; s < NSTEP; s++) begin
            bus(TBL[s].wr, TBL[s].sz, TBL[s].addr, TBL[s].wdata, v, rd);
            if (!TBL[s].wr) begin
                checks++;
                if (!v || rd !== TBL[s].exp) begin
                    errors++;
                    $display("FAIL R%0d step %0d actual=%0h expected=%0h", TBL[s].req, s, rd, TBL[s].exp);
                end
            end else begin
                chk(!v, "R4 no rsp on write", 64'(v), 0);
            end
        end

        // R1 dispatcher view
        chk(vec_addr[64 +: 64] == 64'h11112222_AAAA0001, "R1 vec_addr", vec_addr[64 +: 64], 64'h11112222_AAAA0001);
        chk(vec_data[32 +: 32] == 32'hBEEF, "R1 vec_data", 64'(vec_data[32 +: 32]), 64'hBEEF);

        // R8 / R2: mask transitions on vector 3
        bus(1'b1, 2'd2, 16'h003C, 32'h0, v, rd);
        chk(recheck == NV'(1 << 3), "R8 unmask pulse", 64'(recheck), 64'(1 << 3));
        chk(!vec_masked[3], "R2 mask cleared", 64'(vec_masked[3]), 0);
        @(negedge clk);
        chk(recheck == '0, "R8 pulse one cycle", 64'(recheck), 0);
        bus(1'b1, 2'd2, 16'h003C, 32'h0, v, rd);
        chk(recheck == '0, "R8 0->0 no pulse", 64'(recheck), 0);
        bus(1'b1, 2'd2, 16'h003C, 32'h1, v, rd);
        chk(recheck == '0 && vec_masked[3], "R8 0->1 no pulse", 64'({recheck, vec_masked[3]}), 1);
        bus(1'b1, 2'd2, 16'h003C, 32'h1, v, rd);
        chk(recheck == '0, "R8 1->1 no pulse", 64'(recheck), 0);
        bus(1'b1, 2'd0, 16'h003C, 32'h0, v, rd);
        chk(recheck == '0 && vec_masked[3], "R6 byte unmask ignored", 64'({recheck, vec_masked[3]}), 1);

        // R9 dispatcher set and clear
        @(negedge clk); pend_set[5] = 1'b1;
        @(negedge clk); pend_set[5] = 1'b0;
        chk(pending[5], "R9 set", 64'(pending), 64'(1 << 5));
        pend_set[6] = 1'b1; pend_clr[6] = 1'b1;
        @(negedge clk); pend_set[6] = 1'b0; pend_clr[6] = 1'b0;
        chk(pending == NV'(32'h60), "R9 set wins", 64'(pending), 64'h60);
        pend_clr[5] = 1'b1;
        @(negedge clk); pend_clr[5] = 1'b0;
        chk(pending == NV'(32'h40), "R9 clear", 64'(pending), 64'h40);

        // R10 collision: clear bit 2 in byte 0 while software writes all ones
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2; req_addr = 16'h0800; req_wdata = 32'hFFFFFFFF;
        pend_clr[2] = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; pend_clr[2] = 1'b0;
        rc_after = pending;
        chk(rc_after == NV'(32'h000FFF40), "R10 busy byte kept", 64'(rc_after), 64'h000FFF40);
        bus(1'b0, 2'd2, 16'h0800, 32'h0, v, rd);
        chk(v && rd == 32'h000FFF40, "R10 readback", 64'(rd), 64'h000FFF40);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule